// File: doc/BRIEF.md
# SIMD Lane Result and Flag Collector

This block sits behind a packed-SIMD floating-point slice whose datapath is 64 bits wide. The slice computes four 16-bit lanes side by side. The collector takes the per-lane results and the per-lane five-bit exception flags and turns them into one 64-bit result word and one merged flag word. It registers both outputs, so they appear one clock cycle after the input beat.

A scalar/vector select picks how the inputs are collected. In vector mode, each lane fills its own 16-bit slot of the result. A per-lane mask removes the flags of inactive lanes from the merged word. In scalar mode, only lane 0 matters. Its 16-bit value is placed in the low bits and every bit above it is set to one, so the narrow value stays a valid boxed operand on the wide datapath. The flags in scalar mode come from lane 0 only.

A build-time parameter can turn the masking feature off. With masking off, the mask input has no effect and every lane contributes its flags in vector mode. The lane results themselves are computed elsewhere and arrive as inputs.

Top module: `simd_lane_collector`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted beat, `out_valid`, `result` and `flags` are all zero.
- R2: In vector mode (`vec_mode`=1), lane n's 16-bit value, taken from `lane_res[16n+15:16n]`, appears at `result[16n+15:16n]` one cycle after a beat with `in_valid`=1.
- R3: In scalar mode (`vec_mode`=0), `result[15:0]` equals lane 0's value and `result[63:16]` are all ones, one cycle after the beat.
- R4: A flag word has five bits, ordered from bit 4 down to bit 0 as invalid, divide-by-zero, overflow, underflow, inexact. Lane n's word is `lane_flags[5n+4:5n]`. In vector mode, `flags` is the bitwise OR of the words of all contributing lanes.
- R5: With masking enabled (`MASK_EN`=1) in vector mode, a lane whose `lane_mask` bit is 0 does not contribute. If every mask bit is 0, `flags` is zero.
- R6: In scalar mode, `flags` equals lane 0's flag word, whatever `lane_mask` and the other lanes' flags hold.
- R7: With masking disabled (`MASK_EN`=0), `lane_mask` has no effect and all four lanes contribute in vector mode.
- R8: `out_valid` is `in_valid` delayed by one cycle. After a cycle with `in_valid`=0, `result` and `flags` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Lane inputs hold a beat to collect |
| vec_mode | input | 1 | 1 = vector collection, 0 = scalar lane 0 with boxing |
| lane_res | input | 64 | Per-lane results, lane n at bits [16n+15:16n] |
| lane_flags | input | 20 | Per-lane flag words, lane n at bits [5n+4:5n] |
| lane_mask | input | 4 | Per-lane active bit for flag merging |
| out_valid | output | 1 | Registered result and flags are fresh |
| result | output | 64 | Collected result word |
| flags | output | 5 | Merged flag word {invalid, div-zero, overflow, underflow, inexact} |

## Verification
Every output of this block comes from a register loaded at the clock edge that samples the beat. The result, the merged flags and `out_valid` are therefore all due exactly one cycle after a beat, and none of them has a combinational path from the inputs. Each bench task drives a beat on a falling edge and drops `in_valid` on the next falling edge. It then compares the outputs, half a cycle after the edge that loaded them. The hold check leaves the inputs changed for one further cycle with `in_valid` low and samples at the same offset.

// File: rtl/simd_collect_pkg.sv
package simd_collect_pkg;

    localparam int unsigned FLAG_W = 5;

    // Exception flag word, MSB first.
    typedef struct packed {
        logic nv;   // invalid operation
        logic dz;   // divide by zero
        logic of;   // overflow
        logic uf;   // underflow
        logic nx;   // inexact
    } fflags_t;

endpackage

// File: rtl/slc_lane_gate.sv
module slc_lane_gate
    import simd_collect_pkg::*;
#(
    parameter int unsigned IDX     = 0,
    parameter bit          MASK_EN = 1'b1
) (
    input  fflags_t lane_flags,
    input  logic    mask_bit,
    input  logic    vec_mode,
    output fflags_t eff_flags
);

    localparam bit IS_LANE0 = (IDX == 0);

    logic enable;

    always_comb begin
        // Vector mode: the mask decides unless the feature is off.
        // Scalar mode: only lane 0 speaks.
        if (vec_mode) begin
            enable = mask_bit | ~MASK_EN;
        end else begin
            enable = IS_LANE0;
        end
        eff_flags = enable ? lane_flags : '0;
    end

endmodule

// File: rtl/slc_flag_merge.sv
module slc_flag_merge
    import simd_collect_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  fflags_t [LANES-1:0] gated,
    output fflags_t             merged
);

    always_comb begin
        merged = '0;
        for (int unsigned i = 0; i < LANES; i++) begin
            merged = merged | gated[i];
        end
    end

endmodule

// File: rtl/slc_result_pack.sv
module slc_result_pack #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 16,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] lane_res,
    input  logic              vec_mode,
    output logic [DATA_W-1:0] packed_res
);

    for (genvar n = 0; n < LANES; n++) begin : g_slot
        if (n == 0) begin : g_low
            // Lane 0 sits in the low slot in both modes.
            assign packed_res[LANE_W-1:0] = lane_res[LANE_W-1:0];
        end else begin : g_high
            // Upper slots carry lanes in vector mode, box ones otherwise.
            assign packed_res[n*LANE_W +: LANE_W] =
                vec_mode ? lane_res[n*LANE_W +: LANE_W] : {LANE_W{1'b1}};
        end
    end

endmodule

// File: rtl/simd_lane_collector.sv
module simd_lane_collector
    import simd_collect_pkg::*;
#(
    parameter int unsigned LANES   = 4,
    parameter int unsigned LANE_W  = 16,
    parameter bit          MASK_EN = 1'b1,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    vec_mode,
    input  logic [DATA_W-1:0]       lane_res,
    input  logic [LANES*FLAG_W-1:0] lane_flags,
    input  logic [LANES-1:0]        lane_mask,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       result,
    output logic [FLAG_W-1:0]       flags
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        fflags_t           flg;
    } state_t;

    state_t state_d, state_q;

    fflags_t [LANES-1:0] gated;
    fflags_t             merged;
    logic [DATA_W-1:0]   packed_res;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        slc_lane_gate #(
            .IDX     (n),
            .MASK_EN (MASK_EN)
        ) u_gate (
            .lane_flags (fflags_t'(lane_flags[n*FLAG_W +: FLAG_W])),
            .mask_bit   (lane_mask[n]),
            .vec_mode   (vec_mode),
            .eff_flags  (gated[n])
        );
    end

    slc_flag_merge #(
        .LANES (LANES)
    ) u_merge (
        .gated  (gated),
        .merged (merged)
    );

    slc_result_pack #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_pack (
        .lane_res   (lane_res),
        .vec_mode   (vec_mode),
        .packed_res (packed_res)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = packed_res;
            state_d.flg = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
    assign flags     = state_q.flg;

endmodule

// File: rtl/simd_lane_collector_chk.sv
module simd_lane_collector_chk #(
    parameter int unsigned LANES   = 4,
    parameter int unsigned LANE_W  = 16,
    parameter bit          MASK_EN = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       vec_mode,
    input logic [LANES*LANE_W-1:0]    lane_res,
    input logic [LANES*5-1:0]         lane_flags,
    input logic [LANES-1:0]           lane_mask,
    input logic                       out_valid,
    input logic [LANES*LANE_W-1:0]    result,
    input logic [4:0]                 flags
);

    // R8: valid follows the input beat by one cycle
    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8: outputs hold when no beat
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags)));

    // R2: vector packing
    a_r2_vec_pack: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_mode) |=> (result == $past(lane_res)));

    // R3: scalar boxing
    a_r3_box: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vec_mode) |=>
            ((&result[LANES*LANE_W-1:LANE_W]) &&
             (result[LANE_W-1:0] == $past(lane_res[LANE_W-1:0]))));

    // R6: scalar flags come from lane 0 only
    a_r6_scalar_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vec_mode) |=> (flags == $past(lane_flags[4:0])));

    // R5: all lanes masked off leaves no flags
    a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (MASK_EN && in_valid && vec_mode && (lane_mask == '0)) |=> (flags == '0));

    // R4: no flag appears that no lane raised
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (lane_flags == '0)) |=> (flags == '0));

endmodule

bind simd_lane_collector simd_lane_collector_chk #(
    .LANES   (LANES),
    .LANE_W  (LANE_W),
    .MASK_EN (MASK_EN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .vec_mode   (vec_mode),
    .lane_res   (lane_res),
    .lane_flags (lane_flags),
    .lane_mask  (lane_mask),
    .out_valid  (out_valid),
    .result     (result),
    .flags      (flags)
);

// File: tb/simd_lane_collector_test.sv
module simd_lane_collector_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        vec_mode = 1'b0;
    logic [63:0] lane_res = '0;
    logic [19:0] lane_flags = '0;
    logic [3:0]  lane_mask = '0;

    logic        ov_m, ov_n;
    logic [63:0] res_m, res_n;
    logic [4:0]  flg_m, flg_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_lane_collector #(.MASK_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_mode(vec_mode),
        .lane_res(lane_res), .lane_flags(lane_flags), .lane_mask(lane_mask),
        .out_valid(ov_m), .result(res_m), .flags(flg_m)
    );

    simd_lane_collector #(.MASK_EN(1'b0)) uut_nomask (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_mode(vec_mode),
        .lane_res(lane_res), .lane_flags(lane_flags), .lane_mask(lane_mask),
        .out_valid(ov_n), .result(res_n), .flags(flg_n)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_flags(input logic vec, input logic [19:0] fl,
                                             input logic [3:0] m, input bit use_mask);
        logic [4:0] acc = '0;
        if (!vec) return fl[4:0];
        for (int n = 0; n < 4; n++) begin
            if (!use_mask || m[n]) acc |= fl[n*5 +: 5];
        end
        return acc;
    endfunction

    function automatic logic [63:0] exp_res(input logic vec, input logic [63:0] r);
        return vec ? r : {48'hFFFF_FFFF_FFFF, r[15:0]};
    endfunction

    // Drive one beat, then sample half a cycle after the loading edge.
    task automatic beat(input logic vec, input logic [63:0] r, input logic [19:0] fl,
                        input logic [3:0] m);
        @(negedge clk);
        in_valid = 1'b1; vec_mode = vec; lane_res = r; lane_flags = fl; lane_mask = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check(ov_m == 1'b0 && res_m == '0 && flg_m == '0, "R1 reset state",
              {res_m[58:0], flg_m}, 64'd0);
    endtask

    task automatic t_vec_pack(input logic [63:0] r);
        beat(1'b1, r, 20'd0, 4'hF);
        check(res_m == r, "R2 vector packing", res_m, r);
        check(ov_m == 1'b1, "R8 out_valid after beat", 64'(ov_m), 64'd1);
    endtask

    task automatic t_scalar_box(input logic [63:0] r);
        beat(1'b0, r, 20'd0, 4'h0);
        check(res_m == exp_res(1'b0, r), "R3 scalar NaN-box", res_m, exp_res(1'b0, r));
    endtask

    task automatic t_vec_flags(input logic [19:0] fl, input logic [3:0] m, input string req);
        beat(1'b1, 64'h1234_5678_9ABC_DEF0, fl, m);
        check(flg_m == exp_flags(1'b1, fl, m, 1'b1), req,
              64'(flg_m), 64'(exp_flags(1'b1, fl, m, 1'b1)));
    endtask

    task automatic t_scalar_flags(input logic [19:0] fl, input logic [3:0] m);
        beat(1'b0, 64'h0, fl, m);
        check(flg_m == fl[4:0], "R6 scalar flags lane0 only", 64'(flg_m), 64'(fl[4:0]));
        check(flg_n == fl[4:0], "R6 scalar flags, mask off build", 64'(flg_n), 64'(fl[4:0]));
    endtask

    task automatic t_nomask(input logic [19:0] fl, input logic [3:0] m);
        beat(1'b1, 64'hAAAA_5555_0F0F_F0F0, fl, m);
        check(flg_n == exp_flags(1'b1, fl, m, 1'b0), "R7 mask ignored when disabled",
              64'(flg_n), 64'(exp_flags(1'b1, fl, m, 1'b0)));
        check(flg_m == exp_flags(1'b1, fl, m, 1'b1), "R5 masked build differs",
              64'(flg_m), 64'(exp_flags(1'b1, fl, m, 1'b1)));
    endtask

    task automatic t_hold();
        logic [63:0] r0;
        logic [4:0]  f0;
        beat(1'b1, 64'hCAFE_BEEF_0123_4567, 20'b00001_00010_00100_01000, 4'hF);
        r0 = res_m; f0 = flg_m;
        @(negedge clk);
        vec_mode = 1'b0; lane_res = 64'h0; lane_flags = 20'hFFFFF; lane_mask = 4'h0;
        @(negedge clk);
        check(res_m == r0, "R8 result holds without beat", res_m, r0);
        check(flg_m == f0, "R8 flags hold without beat", 64'(flg_m), 64'(f0));
        check(ov_m == 1'b0, "R8 out_valid low without beat", 64'(ov_m), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vec_pack(64'h0123_4567_89AB_CDEF);
        t_vec_pack(64'hFFFF_0000_8001_7FFE);
        t_scalar_box(64'h5A5A_5A5A_5A5A_3C00);
        t_scalar_box(64'h0000_0000_0000_0000);
        // R4: OR of every lane, bit order nv,dz,of,uf,nx = [4:0]
        t_vec_flags(20'b10000_01000_00100_00011, 4'hF, "R4 OR of all lanes");
        t_vec_flags(20'b00001_00001_00001_00001, 4'hF, "R4 same flag in all lanes");
        // R5: masked lanes excluded
        t_vec_flags(20'b10000_01000_00100_00011, 4'b0101, "R5 partial mask");
        t_vec_flags(20'b11111_11111_11111_11111, 4'b0000, "R5 all masked");
        t_vec_flags(20'b11100_00000_00000_00000, 4'b0111, "R5 only active lanes");
        t_scalar_flags(20'b11110_11101_11011_00101, 4'b0000);
        t_nomask(20'b10000_01000_00100_00010, 4'b0000);
        t_nomask(20'b00001_00000_10000_00000, 4'b1010);
        t_hold();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule